// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port RAM Tile

This block is a 4096-bit synchronous memory tile. Its word width is fixed when the design is built, and the depth and address width follow from that width. The tile has one write side and one read side. Each side has its own clock and its own synchronous clock enable, so a producer and a consumer can run at different rates. The tile also suits single-clock use and first-in first-out buffers.

Each path into and out of the array has its own optional register: write data, write address, write enable, read address, read enable and read data. A parameter either inserts each register or bypasses it. A parameter also chooses which clock, and which enable, drive the read-address and read-enable registers. In single-port mode one address serves both reads and writes.

The array writes itself on the write-clock edge, so callers only need to meet setup and hold to that clock. Two active-low clear inputs, a local one and a chip-wide one, asynchronously zero every register in the tile. The stored words are left untouched by a clear.

Top module: `cfg_ram_tile`

## Requirements
- R1: `WORD_W` may be 16, 8, 4 or 2. The depth is 4096/`WORD_W` and the address width is log2 of the depth, from 8 to 11 bits. Any other width stops elaboration. Every address from 0 to depth-1 names its own word.
- R2: On a rising write-clock edge where `wr_ce` is 1 and the effective write enable is 1, the effective write data is stored at the effective write address. When `wr_ce` is 0, or the effective write enable is 0, nothing is stored.
- R3: On a rising read-clock edge where `rd_ce` is 1 and the effective read enable is 1, the word at the effective read address is captured. With the data-out register bypassed, `rd_data` shows that word right after the edge.
- R4: When one edge of a shared clock both reads and writes the same address, the read returns the word held before that write.
- R5: While `rd_ce` is 0 or the effective read enable is 0, `rd_data` keeps its value.
- R6: Each inserted register loads only when its clock enable is 1, and it adds exactly one edge of its clock to its path. With every register inserted, a read returns data on the third read-clock edge after the request is presented.
- R7: With `RDCTL_ON_WCLK` set, the read-address and read-enable registers load on the write clock and use `wr_ce`. A read request presented while `wr_ce` is 0 is then dropped.
- R8: With `SINGLE_PORT` set, reads use the effective write address and `rd_addr` has no effect.
- R9: While `clr_n` or `chip_rst_n` is 0, every tile register reads as zero, `rd_data` included, without waiting for a clock edge, and no write takes place. Stored words survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write-side clock enable |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read-side clock enable |
| clr_n | input | 1 | Local asynchronous clear, active low |
| chip_rst_n | input | 1 | Chip-wide asynchronous clear, active low |
| wr_data | input | WORD_W | Write data |
| wr_addr | input | AW | Write address; also the shared address in single-port mode |
| wr_en | input | 1 | Write enable |
| rd_addr | input | AW | Read address; ignored in single-port mode |
| rd_en | input | 1 | Read enable |
| rd_data | output | WORD_W | Read data |

## Verification
The bench runs random traffic with random clock enables on an unregistered 256×16 tile. A narrow address range forces frequent same-address collisions; a tile that forwarded new data on a collision would return the freshly written word instead of the old one. The bench also uses a fully registered, single-port 1024×4 tile with read control on the write clock. There it counts read latency edge by edge, and a misplaced register would show the data one cycle early or late. It drives a conflicting `rd_addr` that a single-port tile must ignore, and it presents a read while `wr_ce` is low, which a tile on the wrong control clock would execute. A mid-run clear checks that `rd_data` drops at once while the stored words survive. A tile that reset its array, or that waited for an edge to clear, fails that check.

// File: rtl/cfg_ram_tile.sv
module cfg_ram_tile #(
  parameter int WORD_W        = 16,
  parameter bit SINGLE_PORT   = 1'b0,
  parameter bit REG_WDATA     = 1'b0,
  parameter bit REG_WADDR     = 1'b0,
  parameter bit REG_WEN       = 1'b0,
  parameter bit REG_RADDR     = 1'b0,
  parameter bit REG_REN       = 1'b0,
  parameter bit REG_RDATA     = 1'b0,
  parameter bit RDCTL_ON_WCLK = 1'b0,
  localparam int TOTAL_BITS   = 4096,
  localparam int DEPTH        = TOTAL_BITS / WORD_W,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              rd_clk,
  input  logic              rd_ce,
  input  logic              clr_n,
  input  logic              chip_rst_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);

  localparam bit SHAPE_OK = (WORD_W == 16) || (WORD_W == 8) || (WORD_W == 4) || (WORD_W == 2);

  generate
    if (!SHAPE_OK) begin : g_bad_shape
      $error("cfg_ram_tile: WORD_W must be 16, 8, 4 or 2");
    end
  endgenerate

  logic rst_n;
  assign rst_n = clr_n & chip_rst_n;

  logic ctl_clk, ctl_ce;
  assign ctl_clk = RDCTL_ON_WCLK ? wr_clk : rd_clk;
  assign ctl_ce  = RDCTL_ON_WCLK ? wr_ce  : rd_ce;

  logic [WORD_W-1:0] wd_e;
  logic [AW-1:0]     wa_e, ra_e;
  logic              we_e, re_e;

  // write-side path registers
  generate
    if (REG_WDATA) begin : g_wd_reg
      logic [WORD_W-1:0] q;
      always_ff @(posedge wr_clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (wr_ce) q <= wr_data;
      assign wd_e = q;
    end else begin : g_wd_thru
      assign wd_e = wr_data;
    end

    if (REG_WADDR) begin : g_wa_reg
      logic [AW-1:0] q;
      always_ff @(posedge wr_clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (wr_ce) q <= wr_addr;
      assign wa_e = q;
      p_waddr_hold_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_ce |=> $stable(q));
    end else begin : g_wa_thru
      assign wa_e = wr_addr;
    end

    if (REG_WEN) begin : g_we_reg
      logic q;
      always_ff @(posedge wr_clk or negedge rst_n)
        if (!rst_n) q <= 1'b0;
        else if (wr_ce) q <= wr_en;
      assign we_e = q;
    end else begin : g_we_thru
      assign we_e = wr_en;
    end
  endgenerate

  // read-side control registers
  generate
    if (SINGLE_PORT) begin : g_ra_shared
      assign ra_e = wa_e;
    end else if (REG_RADDR) begin : g_ra_reg
      logic [AW-1:0] q;
      always_ff @(posedge ctl_clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (ctl_ce) q <= rd_addr;
      assign ra_e = q;
      p_raddr_hold_r7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        !ctl_ce |=> $stable(q));
    end else begin : g_ra_thru
      assign ra_e = rd_addr;
    end

    if (REG_REN) begin : g_re_reg
      logic q;
      always_ff @(posedge ctl_clk or negedge rst_n)
        if (!rst_n) q <= 1'b0;
        else if (ctl_ce) q <= rd_en;
      assign re_e = q;
      p_ren_hold_r7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        !ctl_ce |=> $stable(q));
    end else begin : g_re_thru
      assign re_e = rd_en;
    end
  endgenerate

  // storage array with self-timed write
  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_fire;
  assign wr_fire = wr_ce & we_e & rst_n;

  always_ff @(posedge wr_clk)
    if (wr_fire) mem[wa_e] <= wd_e;

  p_write_lands_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |=> mem[$past(wa_e)] == $past(wd_e));

  // array read stage
  logic [WORD_W-1:0] rd_core;
  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) rd_core <= '0;
    else if (rd_ce && re_e) rd_core <= mem[ra_e];

  p_core_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_ce && re_e) |=> $stable(rd_core));

  // optional data-out register
  generate
    if (REG_RDATA) begin : g_rd_reg
      logic [WORD_W-1:0] q;
      always_ff @(posedge rd_clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else if (rd_ce) q <= rd_core;
      assign rd_data = q;
      p_rdata_hold_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_ce |=> $stable(q));
    end else begin : g_rd_thru
      assign rd_data = rd_core;
    end
  endgenerate

  p_clear_out_r9: assert property (@(posedge rd_clk) !rst_n |-> rd_data == '0);

endmodule

// File: tb/sim_cfg_ram_tile.sv
module sim_cfg_ram_tile;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic grst_n;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // u0: 256x16, dual port, no registers
  logic        a_clr, a_wce, a_rce, a_we, a_re;
  logic [15:0] a_wd, a_rdata;
  logic [7:0]  a_wa, a_ra;
  logic [15:0] mem0 [256];
  logic [15:0] exp0;

  cfg_ram_tile #(.WORD_W(16)) u0 (
    .wr_clk(clk), .wr_ce(a_wce), .rd_clk(clk), .rd_ce(a_rce),
    .clr_n(a_clr), .chip_rst_n(grst_n),
    .wr_data(a_wd), .wr_addr(a_wa), .wr_en(a_we),
    .rd_addr(a_ra), .rd_en(a_re), .rd_data(a_rdata));

  // u1: 1024x4, single port, every register, read control on write clock
  logic       b_clr, b_wce, b_we, b_re;
  logic [3:0] b_wd, b_rdata;
  logic [9:0] b_wa, b_ra;

  cfg_ram_tile #(.WORD_W(4), .SINGLE_PORT(1'b1), .REG_WDATA(1'b1), .REG_WADDR(1'b1),
                 .REG_WEN(1'b1), .REG_RADDR(1'b1), .REG_REN(1'b1), .REG_RDATA(1'b1),
                 .RDCTL_ON_WCLK(1'b1)) u1 (
    .wr_clk(clk), .wr_ce(b_wce), .rd_clk(clk), .rd_ce(1'b1),
    .clr_n(b_clr), .chip_rst_n(grst_n),
    .wr_data(b_wd), .wr_addr(b_wa), .wr_en(b_we),
    .rd_addr(b_ra), .rd_en(b_re), .rd_data(b_rdata));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step0(input bit we, input logic [7:0] wa, input logic [15:0] wd,
                       input bit re, input logic [7:0] ra, input bit wce, input bit rce);
    string tag;
    a_we = we; a_wa = wa; a_wd = wd; a_re = re; a_ra = ra; a_wce = wce; a_rce = rce;
    if (rce && re && wce && we && wa == ra) tag = "R4";
    else if (!(rce && re)) tag = "R5";
    else tag = "R3";
    @(posedge clk);
    if (rce && re) exp0 = mem0[ra];
    if (wce && we) mem0[wa] = wd;
    @(negedge clk);
    chk(a_rdata === exp0, tag, a_rdata, exp0);
  endtask

  task automatic cyc1(input bit we, input logic [9:0] a, input logic [3:0] d,
                      input bit re, input logic [9:0] ra, input bit wce);
    b_we = we; b_wa = a; b_wd = d; b_re = re; b_ra = ra; b_wce = wce;
    @(negedge clk);
    b_we = 1'b0; b_wa = 10'd5; b_wd = 4'h0; b_re = 1'b0; b_ra = 10'd0; b_wce = 1'b1;
  endtask

  task automatic idle1(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    grst_n = 1'b0; a_clr = 1'b1; b_clr = 1'b1;
    a_we = 0; a_re = 0; a_wa = 0; a_ra = 0; a_wd = 0; a_wce = 1; a_rce = 1;
    b_we = 0; b_re = 0; b_wa = 10'd5; b_ra = 0; b_wd = 0; b_wce = 1;
    exp0 = '0;
    repeat (3) @(negedge clk);
    chk(a_rdata === 16'h0, "R9", a_rdata, 16'h0);
    chk(b_rdata === 4'h0,  "R9", {12'h0, b_rdata}, 16'h0);
    grst_n = 1'b1;
    @(negedge clk);

    // fill every word of u0; covers the top address (R1)
    for (int i = 0; i < 256; i++) step0(1'b1, 8'(i), 16'(i * 16'h0101 ^ 16'h5a5a), 1'b0, 8'd0, 1'b1, 1'b1);
    step0(1'b0, 8'd0, 16'h0, 1'b1, 8'd255, 1'b1, 1'b1);
    chk(a_rdata === (16'(255 * 16'h0101) ^ 16'h5a5a), "R1", a_rdata, 16'(255 * 16'h0101) ^ 16'h5a5a);

    // directed collision: old word returned (R4)
    step0(1'b1, 8'd7, 16'hbeef, 1'b1, 8'd7, 1'b1, 1'b1);
    chk(a_rdata === (16'(7 * 16'h0101) ^ 16'h5a5a), "R4", a_rdata, 16'(7 * 16'h0101) ^ 16'h5a5a);
    step0(1'b0, 8'd0, 16'h0, 1'b1, 8'd7, 1'b1, 1'b1);
    chk(a_rdata === 16'hbeef, "R2", a_rdata, 16'hbeef);

    // write blocked by wr_ce low (R2)
    step0(1'b1, 8'd7, 16'h1111, 1'b0, 8'd0, 1'b0, 1'b1);
    step0(1'b0, 8'd0, 16'h0, 1'b1, 8'd7, 1'b1, 1'b1);
    chk(a_rdata === 16'hbeef, "R2", a_rdata, 16'hbeef);

    // read held while rd_ce low (R5)
    step0(1'b0, 8'd0, 16'h0, 1'b1, 8'd3, 1'b1, 1'b0);
    chk(a_rdata === 16'hbeef, "R5", a_rdata, 16'hbeef);

    // random traffic, narrow address range
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step0(r[0], 8'(r[5:2]), 16'($urandom), r[1], 8'(r[9:6]), r[10] | r[11], r[12] | r[13]);
    end

    // asynchronous clear, storage retained (R9)
    a_we = 1'b0; a_re = 1'b0;
    #1 a_clr = 1'b0;
    #0.5;
    chk(a_rdata === 16'h0, "R9", a_rdata, 16'h0);
    exp0 = '0;
    @(negedge clk);
    chk(a_rdata === 16'h0, "R9", a_rdata, 16'h0);
    a_clr = 1'b1;
    @(negedge clk);
    step0(1'b0, 8'd0, 16'h0, 1'b1, 8'd200, 1'b1, 1'b1);
    chk(a_rdata === mem0[200], "R9", a_rdata, mem0[200]);

    // u1: fully registered single-port tile
    cyc1(1'b1, 10'd5, 4'ha, 1'b0, 10'd0, 1'b1);    idle1(3);
    cyc1(1'b1, 10'd9, 4'h3, 1'b0, 10'd0, 1'b1);    idle1(3);
    cyc1(1'b1, 10'd0, 4'h1, 1'b0, 10'd0, 1'b1);    idle1(3);
    cyc1(1'b1, 10'd1023, 4'h7, 1'b0, 10'd0, 1'b1); idle1(3);

    // read 5 with rd_addr pointing at 9: latency and shared address (R6, R8)
    cyc1(1'b0, 10'd5, 4'h0, 1'b1, 10'd9, 1'b1);
    idle1(1);
    chk(b_rdata === 4'h0, "R6", {12'h0, b_rdata}, 16'h0);
    idle1(1);
    chk(b_rdata === 4'ha, "R6", {12'h0, b_rdata}, 16'ha);
    chk(b_rdata === 4'ha, "R8", {12'h0, b_rdata}, 16'ha);

    cyc1(1'b0, 10'd0, 4'h0, 1'b1, 10'd5, 1'b1); idle1(4);
    chk(b_rdata === 4'h1, "R1", {12'h0, b_rdata}, 16'h1);
    cyc1(1'b0, 10'd1023, 4'h0, 1'b1, 10'd5, 1'b1); idle1(4);
    chk(b_rdata === 4'h7, "R1", {12'h0, b_rdata}, 16'h7);

    // collision through the registered path (R4)
    cyc1(1'b1, 10'd9, 4'hc, 1'b1, 10'd0, 1'b1); idle1(4);
    chk(b_rdata === 4'h3, "R4", {12'h0, b_rdata}, 16'h3);
    cyc1(1'b0, 10'd9, 4'h0, 1'b1, 10'd0, 1'b1); idle1(4);
    chk(b_rdata === 4'hc, "R2", {12'h0, b_rdata}, 16'hc);

    // read request dropped while wr_ce is low (R7)
    cyc1(1'b0, 10'd5, 4'h0, 1'b1, 10'd5, 1'b0); idle1(4);
    chk(b_rdata === 4'hc, "R7", {12'h0, b_rdata}, 16'hc);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule